// File: doc/BRIEF.md
# Packed Word Dot-Product Accumulator

This block is a SIMD multiply-accumulate datapath. It takes three equal-width vectors: an accumulator vector of 32-bit lanes, and two operand vectors of 16-bit words. Each 32-bit lane takes two word pairs from the operands, one pair from the low word slot and one from the high word slot. It multiplies each pair and adds both products to that lane's accumulator value. A 3-bit mode input sets two things: how each operand is extended before the multiply, and whether the lane sum wraps or is clamped.

A build-time parameter sets the active lane count to either eight lanes (256 bits) or four lanes (128 bits). In the four-lane build the upper half of the result is always zero. There is one register stage at the output. A result is captured, together with a valid flag, on the clock edge that sees `in_valid` high. The captured result holds until the next valid input.

Top module: `wdot_accum`

## Requirements
- R1: Lane j (result bits [32j+31:32j]) uses accumulator bits [32j+31:32j] and operand words 2j and 2j+1 from both operands, where word k sits at bits [16k+15:16k]. The lane forms the product of operand-A word 2j with operand-B word 2j, and the product of operand-A word 2j+1 with operand-B word 2j+1.
- R2: With mode[1:0]=2'b00, operand-A words are sign-extended, operand-B words are zero-extended, and the accumulator lane is read as signed.
- R3: With mode[1:0]=2'b01, operand-A words are zero-extended, operand-B words are sign-extended, and the accumulator lane is read as signed.
- R4: With mode[1:0]=2'b10, both operands' words and the accumulator lane are all zero-extended.
- R5: With mode[2]=0, the lane result is the low 32 bits of accumulator + product0 + product1.
- R6: With mode[2]=1 and mode[1:0] equal to 2'b00 or 2'b01, the lane sum is clamped to the range [-2^31, 2^31-1].
- R7: With mode[2]=1 and mode[1:0]=2'b10, the lane sum is clamped to the range [0, 2^32-1].
- R8: mode[1:0]=2'b11 gives an all-zero result in every lane.
- R9: With the four-lane build (WIDE=0), result bits [255:128] are always zero.
- R10: `out_valid` is high on the cycle after a clock edge that sees `in_valid` high, and low on the cycle after an edge that sees it low. The result of that input is available in the same cycle as `out_valid`.
- R11: An edge that sees `in_valid` low leaves `res_o` unchanged.
- R12: A synchronous active-high `rst` clears `out_valid` and `res_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 3 | [1:0] signedness code, [2] saturate |
| acc_i | input | 256 | Accumulator vector, 32-bit lanes |
| a_i | input | 256 | Operand A, 16-bit words |
| b_i | input | 256 | Operand B, 16-bit words |
| out_valid | output | 1 | Registered result is new this cycle |
| res_o | output | 256 | Registered result vector |

## Verification
The clocked assertions assume that `in_valid` and `mode` hold known values at every edge. They also assume that reset lasts at least one edge. The bench drives every input on the falling edge, keeps `in_valid` low while reset is high, and uses all four signedness codes with both saturate settings. Randomly chosen accumulator values are often pushed toward the signed and unsigned extremes, so that clamping is reached in both directions.

// File: rtl/wdot_pkg.sv
package wdot_pkg;
    typedef enum logic [1:0] {
        SGN_SU  = 2'b00,
        SGN_US  = 2'b01,
        SGN_UU  = 2'b10,
        SGN_BAD = 2'b11
    } sgn_e;
endpackage

// File: rtl/wdot_clamp.sv
module wdot_clamp #(
    parameter int ACC_W = 32,
    parameter int SUM_W = 36
) (
    input  logic                    sat,
    input  logic                    uns,
    input  logic                    bad,
    input  logic signed [SUM_W-1:0] sum,
    output logic [ACC_W-1:0]        res
);
    localparam int HEAD = SUM_W - ACC_W;
    localparam logic signed [SUM_W-1:0] SMAX = {{(HEAD+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SMIN = {{(HEAD+1){1'b1}}, {(ACC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] UMAX = {{HEAD{1'b0}}, {ACC_W{1'b1}}};

    always_comb begin
        res = sum[ACC_W-1:0];
        if (bad) begin
            res = '0;
        end else if (sat && uns) begin
            if (sum < 0)          res = '0;
            else if (sum > UMAX)  res = '1;
        end else if (sat) begin
            if (sum > SMAX)       res = {1'b0, {(ACC_W-1){1'b1}}};
            else if (sum < SMIN)  res = {1'b1, {(ACC_W-1){1'b0}}};
        end
    end

    always_comb begin
        // R6
        if (!bad && sat && !uns)
            sat_sign_chk: assert (res[ACC_W-1] == sum[SUM_W-1]);
        // R7
        if (!bad && sat && uns && (sum > 0))
            usat_nonzero_chk: assert (res != '0);
    end
endmodule

// File: rtl/wdot_lane.sv
module wdot_lane
    import wdot_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ACC_W  = 32
) (
    input  sgn_e              sgn,
    input  logic              sat,
    input  logic [ACC_W-1:0]  acc,
    input  logic [WORD_W-1:0] a_lo,
    input  logic [WORD_W-1:0] a_hi,
    input  logic [WORD_W-1:0] b_lo,
    input  logic [WORD_W-1:0] b_hi,
    output logic [ACC_W-1:0]  res
);
    localparam int PROD_W = 2 * WORD_W + 2;
    localparam int SUM_W  = ACC_W + 4;

    logic a_sgn, b_sgn, w_sgn;
    logic signed [WORD_W:0]    xa0, xa1, xb0, xb1;
    logic signed [PROD_W-1:0]  p0, p1;
    logic signed [SUM_W-1:0]   xw, sum;

    always_comb begin
        a_sgn = (sgn == SGN_SU);
        b_sgn = (sgn == SGN_US);
        w_sgn = (sgn != SGN_UU);
        xa0 = {a_sgn & a_lo[WORD_W-1], a_lo};
        xa1 = {a_sgn & a_hi[WORD_W-1], a_hi};
        xb0 = {b_sgn & b_lo[WORD_W-1], b_lo};
        xb1 = {b_sgn & b_hi[WORD_W-1], b_hi};
        p0  = xa0 * xb0;
        p1  = xa1 * xb1;
        xw  = {{(SUM_W-ACC_W){w_sgn & acc[ACC_W-1]}}, acc};
        sum = xw + {{(SUM_W-PROD_W){p0[PROD_W-1]}}, p0}
                 + {{(SUM_W-PROD_W){p1[PROD_W-1]}}, p1};
    end

    wdot_clamp #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_clamp (
        .sat (sat),
        .uns (sgn == SGN_UU),
        .bad (sgn == SGN_BAD),
        .sum (sum),
        .res (res)
    );
endmodule

// File: rtl/wdot_accum.sv
module wdot_accum
    import wdot_pkg::*;
#(
    parameter int WIDE      = 1,
    parameter int WORD_W    = 16,
    parameter int ACC_W     = 32,
    parameter int MAX_LANES = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [2:0]                     mode,
    input  logic [MAX_LANES*ACC_W-1:0]     acc_i,
    input  logic [MAX_LANES*2*WORD_W-1:0]  a_i,
    input  logic [MAX_LANES*2*WORD_W-1:0]  b_i,
    output logic                           out_valid,
    output logic [MAX_LANES*ACC_W-1:0]     res_o
);
    localparam int VEC_W     = MAX_LANES * ACC_W;
    localparam int ACT_LANES = (WIDE != 0) ? MAX_LANES : MAX_LANES / 2;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } st_t;

    st_t st_d, st_q;
    logic [VEC_W-1:0] lane_vec;
    sgn_e sgn;

    assign sgn = sgn_e'(mode[1:0]);

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        if (j < ACT_LANES) begin : g_on
            wdot_lane #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_lane (
                .sgn  (sgn),
                .sat  (mode[2]),
                .acc  (acc_i[j*ACC_W +: ACC_W]),
                .a_lo (a_i[(2*j)*WORD_W +: WORD_W]),
                .a_hi (a_i[(2*j+1)*WORD_W +: WORD_W]),
                .b_lo (b_i[(2*j)*WORD_W +: WORD_W]),
                .b_hi (b_i[(2*j+1)*WORD_W +: WORD_W]),
                .res  (lane_vec[j*ACC_W +: ACC_W])
            );
        end else begin : g_off
            assign lane_vec[j*ACC_W +: ACC_W] = '0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.res = lane_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_o     = st_q.res;

    // R10
    vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid) |=> out_valid);
    // R10
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !in_valid) |=> !out_valid);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !in_valid) |=> $stable(res_o));
    // R8
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && mode[1:0] == 2'b11) |=> (res_o == '0));
    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && res_o == '0));

    if (WIDE == 0) begin : g_narrow_chk
        // R9
        upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
            res_o[VEC_W-1:VEC_W/2] == '0);
    end
endmodule

// File: tb/tb_wdot_accum.sv
`timescale 1ns/1ps
module tb_wdot_accum;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   mode;
    logic [255:0] acc_i, a_i, b_i;
    logic         out_valid, out_valid_n;
    logic [255:0] res_o, res_n;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    wdot_accum #(.WIDE(1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .acc_i(acc_i), .a_i(a_i), .b_i(b_i),
        .out_valid(out_valid), .res_o(res_o));

    wdot_accum #(.WIDE(0)) dut_n (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .acc_i(acc_i), .a_i(a_i), .b_i(b_i),
        .out_valid(out_valid_n), .res_o(res_n));

    function automatic logic [31:0] exp_lane(logic [31:0] w, logic [15:0] a0, logic [15:0] a1,
                                             logic [15:0] b0, logic [15:0] b1, logic [2:0] md);
        longint ea0, ea1, eb0, eb1, ew, s;
        if (md[1:0] == 2'b11) return 32'h0;
        ea0 = (md[1:0] == 2'b00) ? longint'($signed(a0)) : longint'(a0);
        ea1 = (md[1:0] == 2'b00) ? longint'($signed(a1)) : longint'(a1);
        eb0 = (md[1:0] == 2'b01) ? longint'($signed(b0)) : longint'(b0);
        eb1 = (md[1:0] == 2'b01) ? longint'($signed(b1)) : longint'(b1);
        ew  = (md[1:0] == 2'b10) ? longint'(w) : longint'($signed(w));
        s = ew + ea0 * eb0 + ea1 * eb1;
        if (md[2]) begin
            if (md[1:0] == 2'b10) begin
                if (s < 0) s = 0;
                else if (s > 64'sh0FFFF_FFFF) s = 64'sh0FFFF_FFFF;
            end else begin
                if (s > 64'sd2147483647) s = 64'sd2147483647;
                else if (s < -64'sd2147483648) s = -64'sd2147483648;
            end
        end
        return s[31:0];
    endfunction

    function automatic logic [255:0] exp_vec(logic [255:0] w, logic [255:0] a, logic [255:0] b,
                                             logic [2:0] md, int nl);
        logic [255:0] r = '0;
        for (int j = 0; j < nl; j++)
            r[j*32 +: 32] = exp_lane(w[j*32 +: 32], a[(2*j)*16 +: 16], a[(2*j+1)*16 +: 16],
                                     b[(2*j)*16 +: 16], b[(2*j+1)*16 +: 16], md);
        return r;
    endfunction

    task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [255:0] w, logic [255:0] a, logic [255:0] b, logic [2:0] md);
        @(negedge clk);
        acc_i = w; a_i = a; b_i = b; mode = md; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R10 valid"}, {255'b0, out_valid}, 256'd1);
        chk({req, " wide"}, res_o, exp_vec(w, a, b, md, 8));
        chk({req, " R9 narrow"}, res_n, exp_vec(w, a, b, md, 4));
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [255:0] hold_v, w, a, b;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; in_valid = 1'b0; mode = 3'b000;
        acc_i = '0; a_i = '0; b_i = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset valid", {255'b0, out_valid}, 256'd0);
        chk("R12 reset res", res_o, 256'd0);
        rst = 1'b0;

        // R2 R5: signed A x unsigned B, wrap
        run("R2 R5 su wrap", '0, {16{16'h8000}}, {16{16'hFFFF}}, 3'b000);
        // R6: signed saturation low
        run("R2 R6 su sat min", {8{32'h8000_0000}}, {16{16'h8000}}, {16{16'hFFFF}}, 3'b100);
        // R3 R6: unsigned A x signed B, saturate high
        run("R3 R6 us sat max", {8{32'h7FFF_FFFF}}, {16{16'hFFFF}}, {16{16'h7FFF}}, 3'b101);
        run("R3 R5 us wrap", {8{32'h1234_5678}}, {16{16'hFFFF}}, {16{16'h8001}}, 3'b001);
        // R4 R7: unsigned, saturate at all-ones
        run("R4 R7 uu sat max", {8{32'hFFFF_FFFF}}, {16{16'hFFFF}}, {16{16'hFFFF}}, 3'b110);
        run("R4 R5 uu wrap", {8{32'hFFFF_FFFF}}, {16{16'hFFFF}}, {16{16'hFFFF}}, 3'b010);
        // R8: unused code
        run("R8 bad code", rnd256(), rnd256(), rnd256(), 3'b011);
        run("R8 bad code sat", rnd256(), rnd256(), rnd256(), 3'b111);
        // R1: distinct word per slot, lane j = w + (2j+1) + (2j+2)
        for (int k = 0; k < 16; k++) begin
            a[k*16 +: 16] = 16'(k + 1);
            b[k*16 +: 16] = 16'd1;
        end
        for (int j = 0; j < 8; j++) w[j*32 +: 32] = 32'(j * 1000);
        run("R1 pairing", w, a, b, 3'b010);

        // R11 R10: hold with in_valid low
        hold_v = res_o;
        @(negedge clk);
        acc_i = rnd256(); a_i = rnd256(); b_i = rnd256(); mode = 3'b000;
        @(negedge clk);
        chk("R11 hold", res_o, hold_v);
        chk("R10 idle valid", {255'b0, out_valid}, 256'd0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0] md;
            w = rnd256(); a = rnd256(); b = rnd256();
            md = 3'($urandom);
            if (n % 3 == 0)
                for (int j = 0; j < 8; j++)
                    w[j*32 +: 30] = {30{w[j*32 + 31]}};
            run("R1 R5 R6 R7 random", w, a, b, md);
        end

        // R12: mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12 mid reset res", res_o, 256'd0);
        chk("R12 mid reset narrow", res_n, 256'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule